// File: doc/BRIEF.md
# Battery-Backed Memory Power Supervisor

This block sits between a host and a battery-backed static memory array. It watches three supply comparator flags: supply above the write-protect trip point, supply above the battery voltage, and supply above the power-switch threshold. From these it decides when the host may reach the array, when the array runs from the battery, and when the host processor is held in reset. Each flag passes through a two-flop synchroniser and a glitch filter before the sequencer uses it.

When the supply sags below the trip point, the block protects the memory at once. It holds every array strobe inactive, aborts any write in progress and forces the data pins to high impedance. It also pulls its reset request low. When the supply comes back, protection stays in force for a recovery interval, after which the host may access the array again. The reset request is released only after a longer timeout. A new sag during either interval sends the sequencer straight back to protection.

The battery backup path is armed the first time the supply is seen above the trip point. Until then the array is never switched to the battery.

Top module: `pfs_supervisor`

## Requirements
- R1: After reset the block is in the protected state. The array strobes are high, `dq_hiz` is 1, `rst_req_n` is 0, `src_batt` is 0 and `bkup_en` is 0.
- R2: When access is allowed, the array strobes copy the host strobes. `dq_hiz` is 0 only for a read, which is chip enable low, output enable low and write enable high.
- R3: When the raw trip flag has been low for FILT_LEN+4 consecutive clock cycles, all three array strobes are high and `dq_hiz` is 1. A write that is in progress is cut off.
- R4: The reset request goes low in the same cycle that protection starts. It stays low after the supply also drops below the battery level.
- R5: When the raw trip flag rises and then stays high, access resumes exactly FILT_LEN+4+REC_CYC cycles later.
- R6: The reset request is released exactly RST_CYC-REC_CYC cycles after access resumes, where RST_CYC > REC_CYC. The reset request is never high while access is blocked.
- R7: If the trip flag drops during the recovery interval or the timeout interval, the block returns to protection. The full delays of R5 and R6 then start again from the next rise.
- R8: A low pulse on a flag that lasts fewer than FILT_LEN cycles has no effect on the outputs.
- R9: Once backup is armed, `src_batt` goes to 1 exactly FILT_LEN+4 cycles after both the switch flag and the battery flag drop. It returns to 0 exactly FILT_LEN+4 cycles after either flag rises.
- R10: Before the first time the supply is seen above the trip point, `bkup_en` and `src_batt` stay 0 whatever the flags do. Once set, `bkup_en` stays set until reset.
- R11: While protection is active, every combination of host strobes leaves the array strobes high and `dq_hiz` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vtrip_raw | input | 1 | Comparator flag: supply above the write-protect trip point |
| vbat_raw | input | 1 | Comparator flag: supply above the battery voltage |
| vsw_raw | input | 1 | Comparator flag: supply above the power-switch threshold |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| mem_ce_n | output | 1 | Gated chip enable to the array |
| mem_we_n | output | 1 | Gated write enable to the array |
| mem_oe_n | output | 1 | Gated output enable to the array |
| dq_hiz | output | 1 | 1 forces the data pins to high impedance |
| src_batt | output | 1 | 1 powers the array from the battery, 0 from the external supply |
| bkup_en | output | 1 | Battery backup path armed |
| rst_req_n | output | 1 | 0 asks the open-drain reset pin to pull low |

## Verification
The assertions check the following on every cycle:
- Blocked access always gates all strobes and the data pins.
- A trip flag that stays low past the filter latency always brings protection and reset.
- The reset request is never released while access is blocked.
- The array is never moved to the battery before arming, and arming never clears.

Only the bench scenarios can show the exact delay values: the cycle count of the recovery interval and the reset timeout, the restart after a sag during recovery, glitch rejection, and the source-switch latencies.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    typedef enum logic [2:0] {
        ST_SHIP  = 3'd0,
        ST_PROT  = 3'd1,
        ST_RECOV = 3'd2,
        ST_TOUT  = 3'd3,
        ST_RUN   = 3'd4
    } pfs_state_e;

    localparam int unsigned N_FLAGS = 3;
    localparam int unsigned F_TRIP  = 0;
    localparam int unsigned F_BAT   = 1;
    localparam int unsigned F_SW    = 2;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

    function automatic logic is_read(strobe_t s);
        return !s.ce_n && !s.oe_n && s.we_n;
    endfunction

    function automatic logic access_state(pfs_state_e st);
        return (st == ST_TOUT) || (st == ST_RUN);
    endfunction

endpackage

// File: rtl/pfs_flag_filter.sv
module pfs_flag_filter #(
    parameter int unsigned WIDTH    = 3,
    parameter int unsigned FILT_LEN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] clean
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_flag
        logic              sync1, sync2;
        logic [FILT_LEN-1:0] hist;

        always_ff @(posedge clk) begin
            if (rst) begin
                sync1    <= 1'b0;
                sync2    <= 1'b0;
                hist     <= '0;
                clean[g] <= 1'b0;
            end else begin
                sync1 <= raw[g];
                sync2 <= sync1;
                if (FILT_LEN > 1) begin
                    hist <= {hist[FILT_LEN-2:0], sync2};
                end else begin
                    hist <= sync2;
                end
                if (&hist) begin
                    clean[g] <= 1'b1;
                end else if (~|hist) begin
                    clean[g] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/pfs_sequencer.sv
module pfs_sequencer
    import pfs_pkg::*;
#(
    parameter int unsigned REC_CYC = 100000,
    parameter int unsigned RST_CYC = 12000000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       trip_ok,
    input  logic       bat_ok,
    input  logic       sw_ok,
    output pfs_state_e state,
    output logic       access_en,
    output logic       rst_req_n,
    output logic       armed,
    output logic       on_batt
);
    localparam int unsigned CW = $clog2(RST_CYC + 1);
    localparam logic [CW-1:0] REC_LAST = CW'(REC_CYC - 1);
    localparam logic [CW-1:0] RST_LAST = CW'(RST_CYC - 1);

    pfs_state_e nxt;
    logic [CW-1:0] cnt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_SHIP:  if (trip_ok) nxt = ST_RECOV;
            ST_PROT:  if (trip_ok) nxt = ST_RECOV;
            ST_RECOV: if (!trip_ok) nxt = ST_PROT;
                      else if (cnt == REC_LAST) nxt = ST_TOUT;
            ST_TOUT:  if (!trip_ok) nxt = ST_PROT;
                      else if (cnt == RST_LAST) nxt = ST_RUN;
            ST_RUN:   if (!trip_ok) nxt = ST_PROT;
            default:  nxt = ST_PROT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_SHIP;
            cnt     <= '0;
            armed   <= 1'b0;
            on_batt <= 1'b0;
        end else begin
            state <= nxt;
            if ((nxt == ST_RECOV || nxt == ST_TOUT) && state != ST_SHIP && state != ST_PROT) begin
                cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
            end
            if (trip_ok) begin
                armed <= 1'b1;
            end
            if (sw_ok || bat_ok) begin
                on_batt <= 1'b0;
            end else if (armed) begin
                on_batt <= 1'b1;
            end
        end
    end

    assign access_en = access_state(state);
    assign rst_req_n = (state == ST_RUN);
endmodule

// File: rtl/pfs_strobe_gate.sv
module pfs_strobe_gate
    import pfs_pkg::*;
(
    input  logic    access_en,
    input  strobe_t host,
    output strobe_t mem,
    output logic    hiz
);
    always_comb begin
        if (access_en) begin
            mem = host;
            hiz = !is_read(host);
        end else begin
            mem = STROBE_IDLE;
            hiz = 1'b1;
        end
    end
endmodule

// File: rtl/pfs_supervisor.sv
module pfs_supervisor
    import pfs_pkg::*;
#(
    parameter int unsigned FILT_LEN = 4,
    parameter int unsigned REC_CYC  = 100000,
    parameter int unsigned RST_CYC  = 12000000
) (
    input  logic clk,
    input  logic rst,
    input  logic vtrip_raw,
    input  logic vbat_raw,
    input  logic vsw_raw,
    input  logic host_ce_n,
    input  logic host_we_n,
    input  logic host_oe_n,
    output logic mem_ce_n,
    output logic mem_we_n,
    output logic mem_oe_n,
    output logic dq_hiz,
    output logic src_batt,
    output logic bkup_en,
    output logic rst_req_n
);
    logic [N_FLAGS-1:0] raw_flags, clean_flags;
    pfs_state_e state;
    logic access_en;
    strobe_t host_s, mem_s;

    assign raw_flags[F_TRIP] = vtrip_raw;
    assign raw_flags[F_BAT]  = vbat_raw;
    assign raw_flags[F_SW]   = vsw_raw;

    pfs_flag_filter #(.WIDTH(N_FLAGS), .FILT_LEN(FILT_LEN)) u_filt (
        .clk   (clk),
        .rst   (rst),
        .raw   (raw_flags),
        .clean (clean_flags)
    );

    pfs_sequencer #(.REC_CYC(REC_CYC), .RST_CYC(RST_CYC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .trip_ok   (clean_flags[F_TRIP]),
        .bat_ok    (clean_flags[F_BAT]),
        .sw_ok     (clean_flags[F_SW]),
        .state     (state),
        .access_en (access_en),
        .rst_req_n (rst_req_n),
        .armed     (bkup_en),
        .on_batt   (src_batt)
    );

    assign host_s = '{ce_n: host_ce_n, we_n: host_we_n, oe_n: host_oe_n};

    pfs_strobe_gate u_gate (
        .access_en (access_en),
        .host      (host_s),
        .mem       (mem_s),
        .hiz       (dq_hiz)
    );

    assign mem_ce_n = mem_s.ce_n;
    assign mem_we_n = mem_s.we_n;
    assign mem_oe_n = mem_s.oe_n;
endmodule

// File: rtl/pfs_supervisor_chk.sv
module pfs_supervisor_chk #(
    parameter int unsigned FILT_LEN = 4
) (
    input logic clk,
    input logic rst,
    input logic vtrip_raw,
    input logic access_en,
    input logic host_ce_n,
    input logic host_we_n,
    input logic host_oe_n,
    input logic mem_ce_n,
    input logic mem_we_n,
    input logic mem_oe_n,
    input logic dq_hiz,
    input logic src_batt,
    input logic bkup_en,
    input logic rst_req_n
);
    localparam int unsigned LAT = FILT_LEN + 4;
    logic [7:0] lowcnt;

    always_ff @(posedge clk) begin
        if (rst || vtrip_raw) begin
            lowcnt <= '0;
        end else if (lowcnt != 8'hFF) begin
            lowcnt <= lowcnt + 1'b1;
        end
    end

    // R11
    blocked_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !access_en |-> (mem_ce_n && mem_we_n && mem_oe_n && dq_hiz));

    // R3
    trip_protect_chk: assert property (@(posedge clk) disable iff (rst)
        (32'(lowcnt) >= LAT) |-> (mem_we_n && mem_ce_n && dq_hiz));

    // R4
    trip_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (32'(lowcnt) >= LAT) |-> !rst_req_n);

    // R6
    reset_order_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req_n |-> access_en);

    // R10
    ship_batt_chk: assert property (@(posedge clk) disable iff (rst)
        !bkup_en |-> !src_batt);

    // R10
    arm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        bkup_en |=> bkup_en);

    // R2
    read_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !dq_hiz |-> (!host_ce_n && !host_oe_n && host_we_n));
endmodule

bind pfs_supervisor pfs_supervisor_chk #(.FILT_LEN(FILT_LEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .vtrip_raw (vtrip_raw),
    .access_en (access_en),
    .host_ce_n (host_ce_n),
    .host_we_n (host_we_n),
    .host_oe_n (host_oe_n),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .dq_hiz    (dq_hiz),
    .src_batt  (src_batt),
    .bkup_en   (bkup_en),
    .rst_req_n (rst_req_n)
);

// File: tb/pfs_supervisor_tb.sv
`timescale 1ns/1ps
module pfs_supervisor_tb;
    localparam int FILT = 2;
    localparam int REC  = 20;
    localparam int RSTC = 50;
    localparam int LAT  = FILT + 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vtrip_raw = 1'b0, vbat_raw = 1'b0, vsw_raw = 1'b0;
    logic host_ce_n = 1'b1, host_we_n = 1'b1, host_oe_n = 1'b1;
    logic mem_ce_n, mem_we_n, mem_oe_n, dq_hiz, src_batt, bkup_en, rst_req_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pfs_supervisor #(.FILT_LEN(FILT), .REC_CYC(REC), .RST_CYC(RSTC)) u_dut (
        .clk(clk), .rst(rst),
        .vtrip_raw(vtrip_raw), .vbat_raw(vbat_raw), .vsw_raw(vsw_raw),
        .host_ce_n(host_ce_n), .host_we_n(host_we_n), .host_oe_n(host_oe_n),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .dq_hiz(dq_hiz), .src_batt(src_batt), .bkup_en(bkup_en),
        .rst_req_n(rst_req_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic cond(input int sel);
        case (sel)
            0: return mem_ce_n == 1'b0;
            1: return rst_req_n == 1'b1;
            2: return mem_we_n == 1'b1;
            3: return src_batt == 1'b1;
            default: return src_batt == 1'b0;
        endcase
    endfunction

    task automatic count_until(input int sel, output int n);
        n = 0;
        for (int i = 0; i < 500; i++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (cond(sel)) break;
        end
    endtask

    task automatic cycles(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    task automatic set_host(input logic [2:0] v);
        {host_ce_n, host_we_n, host_oe_n} = v;
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            report();
        end
    end

    initial begin
        int n;
        int bad;
        cycles(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(mem_ce_n && mem_we_n && mem_oe_n && dq_hiz, "R1 strobes",
            {mem_ce_n, mem_we_n, mem_oe_n, dq_hiz}, 15);
        chk(!rst_req_n && !src_batt && !bkup_en, "R1 rst/src/bkup",
            {rst_req_n, src_batt, bkup_en}, 0);

        // R10: flags all low, never armed, no battery switch
        cycles(20);
        chk(!src_batt && !bkup_en, "R10 ship", {src_batt, bkup_en}, 0);

        // R5 / R6 power-up
        set_host(3'b011);
        vtrip_raw = 1'b1; vbat_raw = 1'b1; vsw_raw = 1'b1;
        count_until(0, n);
        chk(n == LAT + REC, "R5 access delay", n, LAT + REC);
        chk(rst_req_n == 1'b0, "R6 reset held at access", rst_req_n, 0);
        count_until(1, n);
        chk(n == RSTC - REC, "R6 reset delay", n, RSTC - REC);
        chk(bkup_en == 1'b1, "R10 armed", bkup_en, 1);

        // R2 truth-table sweep in normal operation
        for (int v = 0; v < 8; v++) begin
            logic ce, we, oe, rd;
            set_host(3'(v));
            #2;
            {ce, we, oe} = 3'(v);
            rd = !ce && !oe && we;
            chk({mem_ce_n, mem_we_n, mem_oe_n} == 3'(v), "R2 pass", {mem_ce_n, mem_we_n, mem_oe_n}, v);
            chk(dq_hiz == !rd, "R2 hiz", dq_hiz, !rd);
            @(negedge clk);
        end

        // R8 glitch of one cycle
        set_host(3'b001);
        vtrip_raw = 1'b0;
        @(negedge clk);
        vtrip_raw = 1'b1;
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!rst_req_n || mem_we_n) bad++;
        end
        chk(bad == 0, "R8 glitch ignored", bad, 0);

        // R3 / R4 power-down during a write
        chk(mem_we_n == 1'b0, "R3 write active", mem_we_n, 0);
        vtrip_raw = 1'b0;
        count_until(2, n);
        chk(n == LAT, "R3 protect delay", n, LAT);
        chk(rst_req_n == 1'b0, "R4 reset with protect", rst_req_n, 0);
        vbat_raw = 1'b0;
        cycles(15);
        chk(rst_req_n == 1'b0, "R4 reset below battery", rst_req_n, 0);

        // R11 protected sweep
        bad = 0;
        for (int v = 0; v < 8; v++) begin
            set_host(3'(v));
            #2;
            if (!(mem_ce_n && mem_we_n && mem_oe_n && dq_hiz)) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R11 ignored", bad, 0);

        // R9 source select: both low -> battery, one back -> external
        vsw_raw = 1'b0;
        count_until(3, n);
        chk(n == LAT, "R9 to battery", n, LAT);
        vsw_raw = 1'b1;
        count_until(4, n);
        chk(n == LAT, "R9 to external", n, LAT);
        vsw_raw = 1'b0;
        cycles(10);
        chk(src_batt == 1'b1, "R9 battery again", src_batt, 1);
        vbat_raw = 1'b1;
        count_until(4, n);
        chk(n == LAT, "R9 bat flag restores", n, LAT);
        vsw_raw = 1'b1;

        // R7 sag during recovery restarts
        set_host(3'b011);
        vtrip_raw = 1'b1;
        cycles(15);
        vtrip_raw = 1'b0;
        cycles(12);
        chk(mem_ce_n == 1'b1, "R7 blocked after sag", mem_ce_n, 1);
        vtrip_raw = 1'b1;
        count_until(0, n);
        chk(n == LAT + REC, "R7 full recovery", n, LAT + REC);
        // sag during timeout interval
        cycles(5);
        vtrip_raw = 1'b0;
        cycles(12);
        chk(!rst_req_n && mem_ce_n, "R7 blocked in timeout", {rst_req_n, mem_ce_n}, 1);
        vtrip_raw = 1'b1;
        count_until(0, n);
        chk(n == LAT + REC, "R7 restart access", n, LAT + REC);
        count_until(1, n);
        chk(n == RSTC - REC, "R7 restart reset", n, RSTC - REC);
        chk(bkup_en == 1'b1, "R10 sticky", bkup_en, 1);

        done = 1'b1;
        report();
    end
endmodule